// File: doc/BRIEF.md
# Latched Seven-Segment Decoder with Ripple Blanking

The block turns a 4-bit binary code into drive levels for a common-anode seven-segment digit. The code passes first through a capture register that follows the input on every clock while the active-low hold control `le_n` is low. It freezes while `le_n` is high, so a shared data bus can be strobed into many digits one at a time. The held code is decoded into seven active-low segment lines. Codes 0 to 9 give the decimal numerals, 10 to 14 give five fixed symbols, and 15 gives a dark digit.

Two blanking paths support multi-digit readouts. The ripple input `rbi_n` suppresses a held zero and reports that suppression on `rbo_out`. The `rbo_out` of one digit is wired to the `rbi_n` of the next less significant digit, so leading zeroes disappear. The ripple pin of a real device is bidirectional, and here it is split in two. `rbo_out` carries the report. `rbo_force_n` is the external pull-down, which darkens the digit whatever the other inputs are, for example to apply a brightness duty cycle. The segment lines and `rbo_out` are registered.

Top module: `seg7_latch_decoder`

## Requirements
- R1: On each rising clock edge with `le_n` low, the capture register loads `code_in`. While `le_n` is high, the held code does not change and the displayed digit does not change, whatever `code_in` does.
- R2: The segment bus is active low, with `seg_n[0]`=a, `[1]`=b, `[2]`=c, `[3]`=d, `[4]`=e, `[5]`=f, `[6]`=g. A 0 lights the segment.
- R3: Held codes 0 to 9 light the usual numerals. As lit sets: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=all, 9=abcdfg.
- R4: Held codes 10 to 14 light fixed symbols: 10=g (minus), 11=adefg (E), 12=bcefg (H), 13=def (L), 14=abefg (P).
- R5: Held code 15 drives all seven segment lines high.
- R6: When `rbi_n` is low and the held code is 0, all segments go high and `rbo_out` goes low. A nonzero held code displays normally whatever `rbi_n` is.
- R7: In every other case `rbo_out` is high, including a held 0 with `rbi_n` high, which shows the numeral 0.
- R8: `rbo_force_n` low drives all segments high on the next edge, whatever the values of `le_n`, `rbi_n` and the held code. The capture register keeps following R1.
- R9: The outputs change one edge after `rbi_n` or `rbo_force_n` change. They change two edges after a `code_in` change that is captured with `le_n` low.
- R10: The synchronous active-high `rst` sets the held code to 15, all segments high and `rbo_out` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| code_in | input | 4 | Binary code to display |
| le_n | input | 1 | Capture enable, active low (high holds) |
| rbi_n | input | 1 | Ripple-blank input, active low |
| rbo_force_n | input | 1 | External forced blank, active low |
| seg_n | output | 7 | Segment drives a..g, active low |
| rbo_out | output | 1 | Ripple-blank report, low while a zero is suppressed |

## Verification
Assertions check four rules on every cycle. The held code stays stable while `le_n` is high. A forced blank darkens the digit on the next edge. A low `rbo_out` always comes with a dark digit and a low `rbi_n` one cycle earlier. Reset leaves the digit dark. Only the bench scenarios show the exact glyph for each of the sixteen codes and the two-edge data latency. They also show that a nonzero code ignores `rbi_n`, and that a code captured under a forced blank appears once the force is released.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
  parameter int CODE_W = 4;
  parameter int SEG_W  = 7;
  localparam logic [CODE_W-1:0] CODE_ZERO  = '0;
  localparam logic [CODE_W-1:0] CODE_DARK  = '1;
  localparam logic [SEG_W-1:0]  SEG_ALLOFF = '1;
endpackage

// File: rtl/seg7_capture.sv
module seg7_capture #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= RST_VAL;
    else if (!hold_n) q <= d;
  end

  p_hold_stable_r1: assert property (@(posedge clk) disable iff (rst)
    hold_n |=> $stable(q));
endmodule

// File: rtl/seg7_glyph.sv
module seg7_glyph
  import seg7_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [SEG_W-1:0]  lit
);
  // lit is active high, bit 0 = segment a ... bit 6 = segment g
  always_comb begin
    unique case (code)
      4'd0:  lit = 7'b011_1111;
      4'd1:  lit = 7'b000_0110;
      4'd2:  lit = 7'b101_1011;
      4'd3:  lit = 7'b100_1111;
      4'd4:  lit = 7'b110_0110;
      4'd5:  lit = 7'b110_1101;
      4'd6:  lit = 7'b111_1101;
      4'd7:  lit = 7'b000_0111;
      4'd8:  lit = 7'b111_1111;
      4'd9:  lit = 7'b110_1111;
      4'd10: lit = 7'b100_0000; // minus
      4'd11: lit = 7'b111_1001; // E
      4'd12: lit = 7'b111_0110; // H
      4'd13: lit = 7'b011_1000; // L
      4'd14: lit = 7'b111_0011; // P
      default: lit = 7'b000_0000; // 15: dark
    endcase
  end
endmodule

// File: rtl/seg7_blank.sv
module seg7_blank
  import seg7_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              rbi_n,
  input  logic              force_n,
  output logic              zero_sup,
  output logic              dark
);
  always_comb begin
    zero_sup = !rbi_n && (code == CODE_ZERO);
    dark     = zero_sup || !force_n;
  end
endmodule

// File: rtl/seg7_latch_decoder.sv
module seg7_latch_decoder
  import seg7_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_in,
  input  logic              le_n,
  input  logic              rbi_n,
  input  logic              rbo_force_n,
  output logic [SEG_W-1:0]  seg_n,
  output logic              rbo_out
);
  logic [CODE_W-1:0] held;
  logic [SEG_W-1:0]  lit;
  logic              zero_sup;
  logic              dark;

  seg7_capture #(.W(CODE_W), .RST_VAL(CODE_DARK)) u_cap (
    .clk(clk), .rst(rst), .hold_n(le_n), .d(code_in), .q(held));

  seg7_glyph u_glyph (.code(held), .lit(lit));

  seg7_blank u_blank (
    .code(held), .rbi_n(rbi_n), .force_n(rbo_force_n),
    .zero_sup(zero_sup), .dark(dark));

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_n   <= SEG_ALLOFF;
      rbo_out <= 1'b1;
    end else begin
      seg_n   <= dark ? SEG_ALLOFF : ~lit;
      rbo_out <= !zero_sup;
    end
  end

  p_force_dark_r8: assert property (@(posedge clk) disable iff (rst)
    !rbo_force_n |=> (seg_n == SEG_ALLOFF));
  p_rbo_dark_r6: assert property (@(posedge clk) disable iff (rst)
    !rbo_out |-> (seg_n == SEG_ALLOFF));
  p_rbo_needs_rbi_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(rbo_out) |-> !$past(rbi_n));
  p_reset_dark_r10: assert property (@(posedge clk)
    rst |=> (seg_n == SEG_ALLOFF && rbo_out));
endmodule

// File: tb/sim_seg7_latch_decoder.sv
module sim_seg7_latch_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] code_in = 4'd0;
  logic       le_n = 1'b1, rbi_n = 1'b1, rbo_force_n = 1'b1;
  logic [6:0] seg_n;
  logic       rbo_out;

  int checks = 0, errors = 0;
  int m_code = 15;
  logic [6:0] m_seg = 7'h7F;
  logic       m_rbo = 1'b1;
  bit         ready = 0;

  always #10 clk = ~clk;

  seg7_latch_decoder u0 (.clk(clk), .rst(rst), .code_in(code_in), .le_n(le_n),
    .rbi_n(rbi_n), .rbo_force_n(rbo_force_n), .seg_n(seg_n), .rbo_out(rbo_out));

  // glyph as a string of lit segments, translated to active-low bits
  function automatic logic [6:0] expect_glyph(int c);
    string s;
    logic [6:0] v = 7'h7F;
    case (c)
      0: s = "abcdef";  1: s = "bc";     2: s = "abdeg";  3: s = "abcdg";
      4: s = "bcfg";    5: s = "acdfg";  6: s = "acdefg"; 7: s = "abc";
      8: s = "abcdefg"; 9: s = "abcdfg"; 10: s = "g";     11: s = "adefg";
      12: s = "bcefg";  13: s = "def";   14: s = "abefg"; default: s = "";
    endcase
    for (int i = 0; i < s.len(); i++) v[s[i] - "a"] = 1'b0;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_code = 15; m_seg = 7'h7F; m_rbo = 1'b1;
    end else begin
      m_rbo = !(rbi_n == 1'b0 && m_code == 0);
      m_seg = (!rbo_force_n || !m_rbo) ? 7'h7F : expect_glyph(m_code);
      if (!le_n) m_code = code_in;
    end
  end

  task automatic check(string tag);
    checks++;
    if (seg_n !== m_seg || rbo_out !== m_rbo) begin
      errors++;
      $display("FAIL %s: seg_n=%b rbo_out=%b expected seg_n=%b rbo_out=%b",
               tag, seg_n, rbo_out, m_seg, m_rbo);
    end
  endtask

  always @(negedge clk) if (ready) begin
    if (!rbo_force_n) check("R8 per-cycle");
    else if (!m_rbo) check("R6 per-cycle");
    else check("R3/R4/R5/R7 per-cycle");
  end

  task automatic drive(int c, bit le, bit rbi, bit frc);
    @(negedge clk);
    #1; code_in = c[3:0]; le_n = le; rbi_n = rbi; rbo_force_n = frc;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    drive(0, 1, 1, 1);
    rst = 1'b0;
    step(1);
    check("R10 reset dark");
    ready = 1;
    // R3 R4 R5 R2: every code with rbi high
    for (int c = 0; c < 16; c++) begin
      drive(c, 0, 1, 1);
      step(2);
      check(c < 10 ? "R3 numeral" : (c < 15 ? "R4 symbol" : "R5 dark"));
    end
    // R1: hold code 8, change input
    drive(8, 0, 1, 1); step(2);
    drive(3, 1, 1, 1); step(3);
    check("R1 held value");
    // R9 latency: capture 1
    drive(1, 0, 1, 1); step(1);
    check("R9 one edge old value"); step(1);
    check("R9 two edge new value");
    // R7: zero with rbi high shows 0
    drive(0, 0, 1, 1); step(2);
    check("R7 zero shown");
    // R6: zero with rbi low suppressed
    drive(0, 1, 0, 1); step(2);
    check("R6 zero suppressed");
    // R6: nonzero ignores rbi
    drive(5, 0, 0, 1); step(2);
    check("R6 nonzero ignores rbi");
    // R8: force overrides capture, rbi, data
    drive(9, 0, 1, 0); step(2);
    check("R8 forced dark");
    drive(0, 0, 0, 0); step(2);
    check("R8 forced with zero suppress");
    drive(7, 1, 1, 0); step(2);
    check("R8 forced while holding");
    drive(7, 1, 1, 1); step(2);
    check("R8 release shows captured code");
    // mixed sweep
    for (int i = 0; i < 200; i++) drive((i * 7) % 16, (i % 3) == 0, (i % 5) != 0, (i % 11) != 0);
    step(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule